// File: doc/BRIEF.md
# UART Line Status and Receive Queue

This block is the buffering and status stage of a UART. A deserializer hands it each received character as a one-cycle strobe with eight data bits and three error tags: break, framing and parity. The block stores the characters in a 16-entry receive queue, or in a single holding register when queue mode is off. It shows the oldest stored character to the CPU. It also produces an 8-bit line status byte that the CPU reads to learn about arrivals, errors and transmitter occupancy.

The line status byte has clear-on-read behaviour. A CPU status read is signalled by a one-cycle strobe. The byte is valid during that cycle, and the flags it clears drop at the next clock edge. The break, framing and parity flags describe the character at the head of the storage. A separate sticky flag reports whether any stored character is in error. The transmitter-empty flags are computed from the transmit occupancy inputs, which are driven by the transmit path.

Top module: `uart_lsr_rxq`

## Requirements
- R1: The status byte `lsr` holds, from bit 7 down to bit 0: receive-error-anywhere, transmitter empty, transmit holding empty, break, framing error, parity error, overrun, data ready.
- R2: Data ready (bit 0) is 1 whenever at least one character is stored. It returns to 0 once the last stored character has been read through `rd_data_stb`.
- R3: In queue mode the storage keeps up to 16 characters and returns them oldest first. A character that arrives while all 16 are held sets overrun (bit 1) and is discarded. The stored characters are left intact.
- R4: With queue mode off the storage is one holding register. A character that arrives while it still holds an unread character replaces that character and sets overrun.
- R5: Overrun is cleared only by a status read. If an overrun happens in the same cycle as a status read, overrun stays set.
- R6: When a character becomes the head of the storage, bits 4..2 take its break, framing and parity tags. This replaces any earlier values. A status read clears those bits unless a new head is loaded in that cycle.
- R7: Bit 7 sets when a character with any error tag is stored. A status read clears it only when no stored character carries an error tag.
- R8: Bit 5 is 1 when `tx_hold_level` is 0. Bit 6 is 1 only when `tx_hold_level` is 0 and `tx_shift_busy` is 0.
- R9: A change of `fifo_en` empties the storage at the next clock edge. A character offered in that same cycle is dropped.
- R10: `rd_data` shows the head character's data, or 0 when the storage is empty. A data read of empty storage has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| rx_valid | input | 1 | One-cycle strobe: a received character is complete |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Break tag of the received character |
| rx_fe | input | 1 | Framing error tag of the received character |
| rx_pe | input | 1 | Parity error tag of the received character |
| rd_data_stb | input | 1 | CPU read of the receive data (removes the head) |
| rd_stat_stb | input | 1 | CPU read of the status byte (clear-on-read) |
| tx_hold_level | input | 5 | Characters in the transmit holding register or queue |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| rd_data | output | 8 | Head character data, 0 when empty |
| lsr | output | 8 | Line status byte |

## Verification
Two things can land in the same cycle: a status read, and a new event that sets a flag, either an overrun or a new head character with error tags. The bench raises `rd_stat_stb` on the very cycle that a seventeenth character hits a full queue. It also raises it on the cycle that a data read promotes a tagged or clean character to the head. Each time, the byte sampled after that edge must show the event's outcome rather than the clear. In a third case, a data read and a status read fall together while errored characters are still stored. The sticky error bit must then survive exactly until the last errored character has left.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_tag_t;

  localparam int LSR_RFE  = 7;
  localparam int LSR_TEMT = 6;
  localparam int LSR_THRE = 5;
  localparam int LSR_BI   = 4;
  localparam int LSR_FE   = 3;
  localparam int LSR_PE   = 2;
  localparam int LSR_OE   = 1;
  localparam int LSR_DR   = 0;

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_in,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  rx_tag_t       push_tag,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output rx_tag_t       head_tag,
  output rx_tag_t       next_tag,
  output logic [CW-1:0] count,
  output logic          flush,
  output logic          push_acc,
  output logic          pop_acc,
  output logic          ovr_evt,
  output logic          ovw_evt
);

  logic [DW-1:0] data_mem [DEPTH];
  rx_tag_t       tag_mem  [DEPTH];

  logic          mode_q;
  logic [AW-1:0] rd_ptr, wr_ptr, rd_ptr_d, wr_ptr_d, rd_inc, wr_inc;
  logic [CW-1:0] count_d;
  logic          cap_full, empty, wr_en;
  logic [AW-1:0] wr_addr;

  assign rd_inc = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
  assign wr_inc = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);

  always_comb begin
    flush    = (mode_in != mode_q);
    empty    = (count == '0);
    cap_full = mode_q ? (count == CW'(DEPTH)) : (count == CW'(1));
    pop_acc  = pop && !empty && !flush;
    push_acc = push && !flush && (!cap_full || pop_acc);
    ovr_evt  = push && !flush && cap_full && !pop_acc;
    ovw_evt  = ovr_evt && !mode_q;
    wr_en    = push_acc || ovw_evt;
    wr_addr  = ovw_evt ? rd_ptr : wr_ptr;
    if (flush) begin
      count_d  = '0;
      rd_ptr_d = '0;
      wr_ptr_d = '0;
    end else begin
      count_d  = count + CW'(push_acc) - CW'(pop_acc);
      rd_ptr_d = pop_acc  ? rd_inc : rd_ptr;
      wr_ptr_d = push_acc ? wr_inc : wr_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      count  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      mode_q <= mode_in;
      count  <= count_d;
      rd_ptr <= rd_ptr_d;
      wr_ptr <= wr_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_addr] <= push_data;
      tag_mem[wr_addr]  <= push_tag;
    end
  end

  assign head_data = data_mem[rd_ptr];
  assign head_tag  = tag_mem[rd_ptr];
  assign next_tag  = tag_mem[rd_inc];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_single_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> count <= CW'(1));
  assert_overrun_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> count == $past(count));

endmodule

// File: rtl/uart_rfe_track.sv
module uart_rfe_track #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push_acc,
  input  logic ovw_evt,
  input  logic push_err,
  input  logic pop_acc,
  input  logic head_err,
  input  logic stat_rd,
  output logic rfe
);

  logic [CW-1:0] err_cnt, err_cnt_d;
  logic          rfe_d, err_in;

  always_comb begin
    err_in = (push_acc || ovw_evt) && push_err;
    if (flush)
      err_cnt_d = '0;
    else
      err_cnt_d = err_cnt + CW'(err_in)
                - CW'((pop_acc || ovw_evt) && head_err);
    if (err_in)
      rfe_d = 1'b1;
    else if (stat_rd && err_cnt_d == '0)
      rfe_d = 1'b0;
    else
      rfe_d = rfe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      rfe     <= 1'b0;
    end else begin
      err_cnt <= err_cnt_d;
      rfe     <= rfe_d;
    end
  end

  assert_rfe_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> rfe);
  assert_rfe_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_in |=> rfe);

endmodule

// File: rtl/uart_lsr_flags.sv
module uart_lsr_flags
  import uart_lsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stat_rd,
  input  logic    load,
  input  rx_tag_t load_tag,
  input  logic    ovr_evt,
  output rx_tag_t head_flags,
  output logic    oe
);

  rx_tag_t head_flags_d;
  logic    oe_d;

  always_comb begin
    if (load)
      head_flags_d = load_tag;
    else if (stat_rd)
      head_flags_d = '0;
    else
      head_flags_d = head_flags;
    if (ovr_evt)
      oe_d = 1'b1;
    else if (stat_rd)
      oe_d = 1'b0;
    else
      oe_d = oe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_flags <= '0;
      oe         <= 1'b0;
    end else begin
      head_flags <= head_flags_d;
      oe         <= oe_d;
    end
  end

  assert_oe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> oe);
  assert_oe_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !stat_rd) |=> oe);
  assert_oe_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !oe);
  assert_head_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> head_flags == $past(load_tag));

endmodule

// File: rtl/uart_lsr_rxq.sv
module uart_lsr_rxq
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TXW   = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fifo_en,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_brk,
  input  logic           rx_fe,
  input  logic           rx_pe,
  input  logic           rd_data_stb,
  input  logic           rd_stat_stb,
  input  logic [TXW-1:0] tx_hold_level,
  input  logic           tx_shift_busy,
  output logic [DW-1:0]  rd_data,
  output logic [7:0]     lsr
);

  rx_tag_t       in_tag, head_tag, next_tag, load_tag, head_flags;
  logic [DW-1:0] head_data;
  logic [CW-1:0] count;
  logic          flush, push_acc, pop_acc, ovr_evt, ovw_evt;
  logic          load_push, load_next, load, rfe, oe, dr, thre, temt;

  assign in_tag = '{brk: rx_brk, fe: rx_fe, pe: rx_pe};

  uart_rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_in   (fifo_en),
    .push      (rx_valid),
    .push_data (rx_data),
    .push_tag  (in_tag),
    .pop       (rd_data_stb),
    .head_data (head_data),
    .head_tag  (head_tag),
    .next_tag  (next_tag),
    .count     (count),
    .flush     (flush),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .ovr_evt   (ovr_evt),
    .ovw_evt   (ovw_evt)
  );

  // A new head appears when a character lands in empty (or just emptied)
  // storage, when a held character is replaced, or when a read exposes
  // the next queued character.
  always_comb begin
    load_next = pop_acc && (count > CW'(1));
    load_push = (push_acc && ((count == '0) || (pop_acc && count == CW'(1))))
              || ovw_evt;
    load      = load_next || load_push;
    load_tag  = load_next ? next_tag : in_tag;
  end

  uart_lsr_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd    (rd_stat_stb),
    .load       (load),
    .load_tag   (load_tag),
    .ovr_evt    (ovr_evt),
    .head_flags (head_flags),
    .oe         (oe)
  );

  uart_rfe_track #(.DEPTH(DEPTH)) u_rfe (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_acc (push_acc),
    .ovw_evt  (ovw_evt),
    .push_err (|in_tag),
    .pop_acc  (pop_acc),
    .head_err (|head_tag),
    .stat_rd  (rd_stat_stb),
    .rfe      (rfe)
  );

  always_comb begin
    dr   = (count != '0);
    thre = (tx_hold_level == '0);
    temt = thre && !tx_shift_busy;
    rd_data = dr ? head_data : '0;
    lsr = '0;
    lsr[LSR_RFE]  = rfe;
    lsr[LSR_TEMT] = temt;
    lsr[LSR_THRE] = thre;
    lsr[LSR_BI]   = head_flags.brk;
    lsr[LSR_FE]   = head_flags.fe;
    lsr[LSR_PE]   = head_flags.pe;
    lsr[LSR_OE]   = oe;
    lsr[LSR_DR]   = dr;
  end

  assert_dr_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lsr[LSR_DR]) |-> ($past(pop_acc) || $past(flush)));
  assert_temt_needs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_shift_busy |-> !lsr[LSR_TEMT]);

endmodule

// File: tb/tb_uart_lsr_rxq.sv
module tb_uart_lsr_rxq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en, rx_valid, rx_brk, rx_fe, rx_pe;
  logic [7:0] rx_data;
  logic       rd_data_stb, rd_stat_stb;
  logic [4:0] tx_hold_level;
  logic       tx_shift_busy;
  logic [7:0] rd_data, lsr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  uart_lsr_rxq dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_brk(rx_brk), .rx_fe(rx_fe), .rx_pe(rx_pe),
    .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
    .tx_hold_level(tx_hold_level), .tx_shift_busy(tx_shift_busy),
    .rd_data(rd_data), .lsr(lsr)
  );

  // {rx_valid, data[7:0], brk fe pe, rd_data_stb, rd_stat_stb, exp_lsr, exp_rd_data}
  localparam int VW = 30;
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 8'h41, 3'b000, 1'b0, 1'b0, 8'h61, 8'h41},
    {1'b1, 8'h42, 3'b001, 1'b0, 1'b0, 8'hE1, 8'h41},
    {1'b1, 8'h43, 3'b010, 1'b0, 1'b0, 8'hE1, 8'h41},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE5, 8'h42},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'hE1, 8'h42},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE9, 8'h43},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE8, 8'h00},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'h60, 8'h00},
    {1'b1, 8'h00, 3'b110, 1'b0, 1'b0, 8'hF9, 8'h00},
    {1'b1, 8'h55, 3'b000, 1'b0, 1'b1, 8'hE1, 8'h00},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b1, 8'h61, 8'h55},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h60, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, return at
  // the next falling edge with strobes released.
  task automatic step(input logic v, input logic [7:0] d, input logic [2:0] tg,
                      input logic rdd, input logic rds);
    rx_valid = v; rx_data = d; {rx_brk, rx_fe, rx_pe} = tg;
    rd_data_stb = rdd; rd_stat_stb = rds;
    @(negedge clk);
    rx_valid = 1'b0; rd_data_stb = 1'b0; rd_stat_stb = 1'b0;
    {rx_brk, rx_fe, rx_pe} = 3'b000; rx_data = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b1; rx_valid = 1'b0; rx_data = 8'h00;
    rx_brk = 1'b0; rx_fe = 1'b0; rx_pe = 1'b0;
    rd_data_stb = 1'b0; rd_stat_stb = 1'b0;
    tx_hold_level = 5'd0; tx_shift_busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset lsr", lsr, 8'h60);
    check("R10 reset rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 idle after reset", lsr, 8'h60);

    // R1 R2 R6 R7 R10: queue-mode vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][29], VEC[i][28:21], VEC[i][20:18], VEC[i][17], VEC[i][16]);
      check($sformatf("R6/R7 vector %0d lsr", i), lsr, VEC[i][15:8]);
      check($sformatf("R10 vector %0d rd_data", i), rd_data, VEC[i][7:0]);
    end

    // R3: fill the queue, then overflow it while a status read happens (R5)
    for (int i = 0; i < 16; i++) step(1'b1, 8'h80 + 8'(i), 3'b000, 1'b0, 1'b0);
    check("R3 full queue lsr", lsr, 8'h61);
    step(1'b1, 8'hEE, 3'b000, 1'b0, 1'b1);
    check("R5 overrun wins over status read", lsr, 8'h63);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    check("R5 overrun cleared by status read", lsr, 8'h61);
    for (int i = 0; i < 16; i++) begin
      check("R3 queue order", rd_data, 8'h80 + 8'(i));
      step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    end
    check("R2 drained lsr", lsr, 8'h60);
    check("R3 dropped char absent", rd_data, 8'h00);

    // R4: single holding register
    fifo_en = 1'b0;
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
    step(1'b1, 8'h11, 3'b000, 1'b0, 1'b0);
    check("R4 held char", rd_data, 8'h11);
    step(1'b1, 8'h22, 3'b001, 1'b0, 1'b0);
    check("R4 overwrite lsr", lsr, 8'hE7);
    check("R4 overwrite data", rd_data, 8'h22);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R5 overrun survives data read", lsr, 8'hE6);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    check("R7 status read clears all", lsr, 8'h60);
    step(1'b1, 8'h33, 3'b010, 1'b0, 1'b0);
    check("R6 framing on held char", lsr, 8'hE9);
    step(1'b1, 8'h44, 3'b000, 1'b0, 1'b0);
    check("R6 framing replaced by clean load", lsr, 8'hE3);
    check("R4 second overwrite data", rd_data, 8'h44);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b1);
    check("R7 clear with no errored chars", lsr, 8'h60);

    // R9: mode change empties storage
    fifo_en = 1'b1;
    step(1'b1, 8'h99, 3'b000, 1'b0, 1'b0);
    check("R9 char during mode change dropped", lsr, 8'h60);
    for (int i = 1; i <= 3; i++) step(1'b1, 8'(i), 3'b000, 1'b0, 1'b0);
    check("R9 chars stored", rd_data, 8'h01);
    fifo_en = 1'b0;
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
    check("R9 flushed lsr", lsr, 8'h60);
    check("R9 flushed data", rd_data, 8'h00);
    fifo_en = 1'b1;
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);

    // R10: data read of empty storage does nothing
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R10 empty read lsr", lsr, 8'h60);
    step(1'b1, 8'h77, 3'b000, 1'b0, 1'b0);
    check("R10 head after empty read", rd_data, 8'h77);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);

    // R8: transmitter occupancy
    tx_hold_level = 5'd3; tx_shift_busy = 1'b1; #1;
    check("R8 both busy", {6'd0, lsr[6:5]}, 8'h00);
    tx_hold_level = 5'd0; #1;
    check("R8 holding empty, shifter busy", {6'd0, lsr[6:5]}, 8'h01);
    tx_shift_busy = 1'b0; #1;
    check("R8 all empty", {6'd0, lsr[6:5]}, 8'h03);
    tx_hold_level = 5'd16; #1;
    check("R8 holding full", {6'd0, lsr[6:5]}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule